// File: doc/BRIEF.md
# Stack-Addressed Register File

This block holds eight 80-bit registers that are named by their distance from a moving top-of-stack pointer, not by a fixed index. Relative slot 0 is always the most recent entry, slot 1 the one beneath it, and so on down to slot 7. The block supports three kinds of operation: loading a value from an external operand bus onto the stack, discarding the top entry, and adding two operands. Every add uses slot 0 as one of its two operands.

There are three add forms. The first adds the operand bus into slot 0. The second adds slot 0 and a chosen relative slot, and writes the sum to either of them. The third adds slot 0 and slot 1, stores the sum one place below the top and then removes the top entry, so the sum becomes the new top. For these adds the entries are plain unsigned integers and the sum wraps modulo 2^80.

Each operation completes on one rising clock edge. An occupancy count guards the stack against pushing onto a full stack and against reading or removing entries that are not there. Such a faulting operation leaves the state untouched and raises a flag for one cycle.

Top module: `stack_regfile`

## Requirements
- R1: An active-low reset empties the stack, clears every entry to zero and drops both flags. The operation codes are: 0 none, 1 push, 2 pop, 3 add-operand-bus, 4 add-relative, 5 add-and-pop. Codes 6 and 7 behave as code 0.
- R2: A push (code 1) on a stack holding fewer than 8 entries makes the operand-bus value the new slot 0. Every older entry moves one slot deeper.
- R3: A push on a stack holding 8 entries raises the overflow flag and changes neither the top value nor any stored entry.
- R4: A pop (code 2) on a non-empty stack removes slot 0, and the former slot 1 becomes slot 0.
- R5: A pop on an empty stack raises the underflow flag and changes nothing.
- R6: Code 3 on a non-empty stack replaces slot 0 with (slot 0 + operand bus) mod 2^80. The depth does not change.
- R7: Code 4 with write-select 1 replaces relative slot i (the 3-bit index input) with slot 0 + slot i. Slot 0 and the depth do not change.
- R8: Code 4 with write-select 0 replaces slot 0 with slot 0 + slot i. Slot i and the depth do not change.
- R9: Code 5 on a stack with at least 2 entries stores slot 0 + slot 1 in slot 1 and then pops, so the new slot 0 is the sum and the depth drops by one.
- R10: An add that needs an entry that is not there raises underflow and changes nothing. Code 3 needs at least 1 entry, code 4 needs more than i entries, and code 5 needs at least 2.
- R11: Each flag is high only in the cycle after its faulting operation. The two flags are never high together.
- R12: The pointer wraps modulo 8, so long interleaved push and pop sequences keep strict last-in first-out order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code |
| rel_i | input | 3 | Relative slot index for code 4 |
| wb_sel_i | input | 1 | Code 4 destination: 1 writes slot i, 0 writes slot 0 |
| mem_i | input | 80 | Operand bus for push and code 3 |
| top_o | output | 80 | Current value of relative slot 0 |
| ovf_o | output | 1 | Overflow flag, one cycle |
| unf_o | output | 1 | Underflow flag, one cycle |

## Verification
Every result is due on the first rising edge after the operation is presented: the new top value, the changed depth and either flag. No result takes longer. The bench therefore changes inputs on falling edges and reads the outputs on the next falling edge, exactly one edge after the operation. Slots below the top cannot be read directly, so their contents are checked by popping them into slot 0 one at a time, each pop again being read one edge later.

// File: rtl/stack_regfile_pkg.sv
package stack_regfile_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_PUSH    = 3'd1,
    OP_POP     = 3'd2,
    OP_ADD_MEM = 3'd3,
    OP_ADD_REL = 3'd4,
    OP_ADD_POP = 3'd5
  } op_e;

  // decoded intent of one operation
  typedef struct packed {
    logic push;    // pointer moves down, entry written at new top
    logic pop;     // pointer moves up after any write
    logic wr;      // one entry is written this cycle
    logic load;    // written value is the operand bus, not the sum
    logic b_mem;   // second adder operand is the operand bus
    logic ovf;     // push on full stack
    logic unf;     // entry needed but absent
  } ctl_t;

endpackage

// File: rtl/stack_regfile_decode.sv
module stack_regfile_decode
  import stack_regfile_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [2:0]       op_i,
  input  logic [IDX_W-1:0] rel_i,
  input  logic             wb_sel_i,
  input  logic [CNT_W-1:0] count_i,
  output ctl_t             ctl_o,
  output logic [IDX_W-1:0] dst_rel_o,
  output logic [IDX_W-1:0] b_rel_o
);

  logic [CNT_W-1:0] rel_w;
  logic             is_full;
  logic             is_empty;

  assign rel_w    = CNT_W'(rel_i);
  assign is_full  = (count_i == CNT_W'(DEPTH));
  assign is_empty = (count_i == '0);

  always_comb begin
    ctl_o     = '0;
    dst_rel_o = '0;
    b_rel_o   = rel_i;
    case (op_i)
      OP_PUSH: begin
        if (is_full) ctl_o.ovf = 1'b1;
        else begin
          ctl_o.push = 1'b1;
          ctl_o.wr   = 1'b1;
          ctl_o.load = 1'b1;
        end
      end
      OP_POP: begin
        if (is_empty) ctl_o.unf = 1'b1;
        else          ctl_o.pop = 1'b1;
      end
      OP_ADD_MEM: begin
        if (is_empty) ctl_o.unf = 1'b1;
        else begin
          ctl_o.wr    = 1'b1;
          ctl_o.b_mem = 1'b1;
        end
      end
      OP_ADD_REL: begin
        if (count_i <= rel_w) ctl_o.unf = 1'b1;
        else begin
          ctl_o.wr  = 1'b1;
          dst_rel_o = wb_sel_i ? rel_i : '0;
        end
      end
      OP_ADD_POP: begin
        b_rel_o = IDX_W'(1);
        if (count_i < CNT_W'(2)) ctl_o.unf = 1'b1;
        else begin
          ctl_o.wr  = 1'b1;
          ctl_o.pop = 1'b1;
          dst_rel_o = IDX_W'(1);
        end
      end
      default: ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/stack_regfile_pointer.sv
module stack_regfile_pointer #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             ovf_ev_i,
  input  logic             unf_ev_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             unf_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_o   <= '0;
      count_o <= '0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
    end else begin
      ovf_o <= ovf_ev_i;
      unf_o <= unf_ev_i;
      if (push_i) begin
        ptr_o   <= ptr_o - IDX_W'(1);
        count_o <= count_o + CNT_W'(1);
      end else if (pop_i) begin
        ptr_o   <= ptr_o + IDX_W'(1);
        count_o <= count_o - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/stack_regfile_bank.sv
module stack_regfile_bank #(
  parameter int WIDTH = 80,
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] rd_a_o,
  output logic [WIDTH-1:0] rd_b_o
);

  logic [WIDTH-1:0] entry [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry[g] <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
        entry[g] <= wr_data_i;
    end
  end

  assign rd_a_o = entry[rd_a_idx_i];
  assign rd_b_o = entry[rd_b_idx_i];

endmodule

// File: rtl/stack_regfile.sv
module stack_regfile
  import stack_regfile_pkg::*;
#(
  parameter int WIDTH = 80,
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_i,
  input  logic [IDX_W-1:0] rel_i,
  input  logic             wb_sel_i,
  input  logic [WIDTH-1:0] mem_i,
  output logic [WIDTH-1:0] top_o,
  output logic             ovf_o,
  output logic             unf_o
);

  // integer sum that discards the carry out of the top bit
  function automatic logic [WIDTH-1:0] wrap_add(input logic [WIDTH-1:0] a,
                                                input logic [WIDTH-1:0] b);
    return a + b;
  endfunction

  // relative slot to physical entry, modulo the power-of-two depth
  function automatic logic [IDX_W-1:0] to_phys(input logic [IDX_W-1:0] top,
                                               input logic [IDX_W-1:0] rel);
    return top + rel;
  endfunction

  // named internal events, visible to the bound checker
  ctl_t             ctl;
  logic [IDX_W-1:0] dst_rel;
  logic [IDX_W-1:0] b_rel;
  logic [IDX_W-1:0] ptr;
  logic [CNT_W-1:0] count;
  logic             push_ev;
  logic             pop_ev;
  logic             ovf_ev;
  logic             unf_ev;
  logic [IDX_W-1:0] b_idx;
  logic [IDX_W-1:0] wr_idx;
  logic [WIDTH-1:0] opnd_a;
  logic [WIDTH-1:0] slot_b;
  logic [WIDTH-1:0] opnd_b;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] wr_data;

  stack_regfile_decode #(.DEPTH(DEPTH)) u_decode (
    .op_i     (op_i),
    .rel_i    (rel_i),
    .wb_sel_i (wb_sel_i),
    .count_i  (count),
    .ctl_o    (ctl),
    .dst_rel_o(dst_rel),
    .b_rel_o  (b_rel)
  );

  assign push_ev = ctl.push;
  assign pop_ev  = ctl.pop;
  assign ovf_ev  = ctl.ovf;
  assign unf_ev  = ctl.unf;

  stack_regfile_pointer #(.DEPTH(DEPTH)) u_pointer (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_ev),
    .pop_i   (pop_ev),
    .ovf_ev_i(ovf_ev),
    .unf_ev_i(unf_ev),
    .ptr_o   (ptr),
    .count_o (count),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o)
  );

  assign b_idx   = to_phys(ptr, b_rel);
  assign wr_idx  = ctl.push ? (ptr - IDX_W'(1)) : to_phys(ptr, dst_rel);
  assign opnd_b  = ctl.b_mem ? mem_i : slot_b;
  assign sum     = wrap_add(opnd_a, opnd_b);
  assign wr_data = ctl.load ? mem_i : sum;

  stack_regfile_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx_i(ptr),
    .rd_b_idx_i(b_idx),
    .wr_en_i   (ctl.wr),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_a_o    (opnd_a),
    .rd_b_o    (slot_b)
  );

  assign top_o = opnd_a;

endmodule

// File: rtl/stack_regfile_chk.sv
module stack_regfile_chk #(
  parameter int WIDTH = 80,
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] mem_i,
  input logic [WIDTH-1:0] top_o,
  input logic             ovf_o,
  input logic             unf_o,
  input logic [IDX_W-1:0] ptr,
  input logic [CNT_W-1:0] count,
  input logic             push_ev,
  input logic             pop_ev,
  input logic             ovf_ev,
  input logic             unf_ev
);

  p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && unf_o));

  p_flag_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    unf_ev |=> unf_o);

  p_overflow_only_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |-> (count == CNT_W'(DEPTH)));

  p_fault_freezes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev || unf_ev) |=> ($stable(ptr) && $stable(count) && $stable(top_o)));

  p_push_loads_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> ((top_o == $past(mem_i)) && (count == $past(count) + CNT_W'(1))));

  p_pop_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |=> ((count == $past(count) - CNT_W'(1)) && (ptr == $past(ptr) + IDX_W'(1))));

  p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

endmodule

bind stack_regfile stack_regfile_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mem_i  (mem_i),
  .top_o  (top_o),
  .ovf_o  (ovf_o),
  .unf_o  (unf_o),
  .ptr    (ptr),
  .count  (count),
  .push_ev(push_ev),
  .pop_ev (pop_ev),
  .ovf_ev (ovf_ev),
  .unf_ev (unf_ev)
);

// File: tb/stack_regfile_test.sv
module stack_regfile_test;

  localparam logic [2:0] C_NOP = 3'd0, C_PUSH = 3'd1, C_POP = 3'd2,
                         C_AMEM = 3'd3, C_AREL = 3'd4, C_APOP = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = C_NOP;
  logic [2:0]  rel_i = '0;
  logic        wb_sel_i = 1'b0;
  logic [79:0] mem_i = '0;
  logic [79:0] top_o;
  logic        ovf_o;
  logic        unf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stack_regfile uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .rel_i(rel_i),
    .wb_sel_i(wb_sel_i), .mem_i(mem_i),
    .top_o(top_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic ov, input logic un);
    chk(req, {78'd0, ovf_o, unf_o}, {78'd0, ov, un});
  endtask

  // present an op at a falling edge; results are read one rising edge later
  task automatic do_op(input logic [2:0] op, input logic [2:0] rel,
                       input logic wb, input logic [79:0] mem);
    op_i = op; rel_i = rel; wb_sel_i = wb; mem_i = mem;
    @(negedge clk);
    op_i = C_NOP; rel_i = '0; wb_sel_i = 1'b0; mem_i = '0;
  endtask

  task automatic push(input logic [79:0] v);
    do_op(C_PUSH, 3'd0, 1'b0, v);
  endtask

  task automatic reset_dut();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    reset_dut();
    chk("R1 top after reset", top_o, 80'd0);
    chk_flags("R1 flags after reset", 1'b0, 1'b0);
    do_op(3'd7, 3'd0, 1'b0, 80'd55);
    chk("R1 code 7 no effect", top_o, 80'd0);
    chk_flags("R1 code 7 no flags", 1'b0, 1'b0);
    do_op(C_POP, 3'd0, 1'b0, '0);
    chk_flags("R1 empty after reset", 1'b0, 1'b1);
  endtask

  task automatic t_push_pop();
    reset_dut();
    push(80'h1234);
    chk("R2 first push", top_o, 80'h1234);
    push(80'hABCD_0000_0000_0000_0001);
    chk("R2 second push", top_o, 80'hABCD_0000_0000_0000_0001);
    chk_flags("R2 no flags", 1'b0, 1'b0);
    do_op(C_POP, 3'd0, 1'b0, '0);
    chk("R4 pop exposes older", top_o, 80'h1234);
    chk_flags("R4 no flags", 1'b0, 1'b0);
  endtask

  task automatic t_underflow_pop();
    reset_dut();
    push(80'd9);
    do_op(C_POP, 3'd0, 1'b0, '0);
    do_op(C_POP, 3'd0, 1'b0, '0);
    chk_flags("R5 pop empty", 1'b0, 1'b1);
    do_op(C_NOP, 3'd0, 1'b0, '0);
    chk_flags("R11 flag one cycle", 1'b0, 1'b0);
    push(80'd4);
    chk("R5 state intact after fault", top_o, 80'd4);
  endtask

  task automatic t_overflow();
    reset_dut();
    for (int k = 1; k <= 8; k++) push(80'(k));
    chk_flags("R3 eight pushes fit", 1'b0, 1'b0);
    push(80'd99);
    chk_flags("R3 overflow flag", 1'b1, 1'b0);
    chk("R3 top unchanged", top_o, 80'd8);
    for (int k = 8; k >= 1; k--) begin
      chk("R3 entries intact", top_o, 80'(k));
      do_op(C_POP, 3'd0, 1'b0, '0);
    end
    chk_flags("R4 last pop clean", 1'b0, 1'b0);
    do_op(C_POP, 3'd0, 1'b0, '0);
    chk_flags("R5 drained", 1'b0, 1'b1);
  endtask

  task automatic t_add_mem();
    reset_dut();
    push(80'd100);
    do_op(C_AMEM, 3'd0, 1'b0, 80'd23);
    chk("R6 add bus", top_o, 80'd123);
    push({80{1'b1}});
    do_op(C_AMEM, 3'd0, 1'b0, 80'd2);
    chk("R6 wrap", top_o, 80'd1);
    do_op(C_POP, 3'd0, 1'b0, '0);
    chk("R6 depth kept", top_o, 80'd123);
  endtask

  task automatic t_add_rel_to_i();
    reset_dut();
    push(80'd10); push(80'd20); push(80'd30); push(80'd40);
    do_op(C_AREL, 3'd2, 1'b1, '0);
    chk("R7 top unchanged", top_o, 80'd40);
    chk_flags("R7 no flags", 1'b0, 1'b0);
    do_op(C_POP, 3'd0, 1'b0, '0);
    chk("R7 slot1 unchanged", top_o, 80'd30);
    do_op(C_POP, 3'd0, 1'b0, '0);
    chk("R7 slot2 holds sum", top_o, 80'd60);
    do_op(C_POP, 3'd0, 1'b0, '0);
    chk("R7 slot3 unchanged", top_o, 80'd10);
  endtask

  task automatic t_add_rel_to_top();
    reset_dut();
    push(80'd5); push(80'd7); push(80'd9);
    do_op(C_AREL, 3'd2, 1'b0, '0);
    chk("R8 top holds sum", top_o, 80'd14);
    do_op(C_POP, 3'd0, 1'b0, '0);
    chk("R8 slot1 unchanged", top_o, 80'd7);
    do_op(C_POP, 3'd0, 1'b0, '0);
    chk("R8 slot2 unchanged", top_o, 80'd5);
  endtask

  task automatic t_add_pop();
    reset_dut();
    push(80'd1000); push(80'd100); push(80'd23);
    do_op(C_APOP, 3'd0, 1'b0, '0);
    chk("R9 sum at new top", top_o, 80'd123);
    do_op(C_POP, 3'd0, 1'b0, '0);
    chk("R9 depth dropped", top_o, 80'd1000);
    do_op(C_POP, 3'd0, 1'b0, '0);
    do_op(C_POP, 3'd0, 1'b0, '0);
    chk_flags("R9 stack now empty", 1'b0, 1'b1);
  endtask

  task automatic t_add_underflow();
    reset_dut();
    do_op(C_AMEM, 3'd0, 1'b0, 80'd3);
    chk_flags("R10 add bus empty", 1'b0, 1'b1);
    push(80'd1);
    do_op(C_APOP, 3'd0, 1'b0, '0);
    chk_flags("R10 add-pop one entry", 1'b0, 1'b1);
    chk("R10 top kept", top_o, 80'd1);
    do_op(C_AREL, 3'd1, 1'b1, '0);
    chk_flags("R10 rel beyond depth", 1'b0, 1'b1);
    do_op(C_AREL, 3'd0, 1'b1, '0);
    chk_flags("R11 flag clears", 1'b0, 1'b0);
    chk("R10 rel zero allowed", top_o, 80'd2);
  endtask

  task automatic t_wrap();
    reset_dut();
    for (int k = 0; k < 7; k++) begin
      push(80'(k));
      push(80'(k + 100));
      do_op(C_POP, 3'd0, 1'b0, '0);
      chk("R12 interleave", top_o, 80'(k));
    end
    for (int k = 6; k >= 0; k--) begin
      chk("R12 lifo after wrap", top_o, 80'(k));
      do_op(C_POP, 3'd0, 1'b0, '0);
    end
    chk_flags("R12 empty at end", 1'b0, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_push_pop();
    t_underflow_pop();
    t_overflow();
    t_add_mem();
    t_add_rel_to_i();
    t_add_rel_to_top();
    t_add_pop();
    t_add_underflow();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule